// File: doc/BRIEF.md
# Keyboard and Display Register Bank

This block is a small peripheral register bank on a 16-bit processor bus. It claims the top page of the address space (0xFE00 and above) for input/output and places four device registers in it: a keyboard status word, a keyboard character word, a display status word and a display character word. Any access below 0xFE00 is handed to ordinary memory through a memory-enable output. At or above 0xFE00 that output stays low, so memory stays silent while the bank drives the read bus.

Characters enter from a keyboard source and leave toward a display sink, each over an 8-bit valid/ready stream. On the keyboard side the bank raises `kbd_ready` only when it has room. That is when no unread character is held, or when the processor reads the held character in that same cycle. A source must keep `kbd_valid` and `kbd_char` steady until it sees `kbd_ready`. On the display side `disp_valid` is high while a byte written by the processor is waiting. `disp_char` does not change until the sink raises `disp_ready`. The sink may stall for any number of cycles.

Software polls two flags. The keyboard-ready flag is set when a character arrives and cleared when the character word is read. The display-ready flag is cleared when a character is written and set again when the sink accepts that character. Each status word also holds a software-writable interrupt-enable bit.

Top module: `kbd_disp_regbank`

## Requirements
- R1: `mem_en` is 1 exactly when `bus_valid` is 1 and `bus_addr` < 0xFE00. It is 0 for every address from 0xFE00 to 0xFFFF.
- R2: A read of 0xFE00 (keyboard status) returns bit 15 = keyboard-ready flag, bit 14 = keyboard interrupt enable, and 0 in all other bits.
- R3: A keyboard transfer happens when `kbd_valid` and `kbd_ready` are both 1 at a clock edge. It latches `kbd_char` and sets the keyboard-ready flag. `kbd_ready` is 1 when the flag is clear, or when the current cycle is a read of 0xFE02.
- R4: A read of 0xFE02 returns the held character in bits 7:0 and zeros above. At the following edge it clears the keyboard-ready flag. The exception is a keyboard transfer in the same cycle: the flag then stays set and the new character replaces the old one.
- R5: A read of 0xFE04 (display status) returns bit 15 = display-ready flag, bit 14 = display interrupt enable, and 0 elsewhere. After reset the display-ready flag is 1.
- R6: A write to 0xFE06 while display-ready is 1 latches `bus_wdata[7:0]` and clears display-ready. `disp_valid` then goes to 1 with that byte on `disp_char`. A write to 0xFE06 while display-ready is 0 has no effect.
- R7: While `disp_valid` is 1 and `disp_ready` is 0, `disp_valid` and `disp_char` hold. A handshake (`disp_valid` and `disp_ready`) sets display-ready again, and `disp_valid` drops at the next edge.
- R8: A write to 0xFE00 or 0xFE04 loads bit 14 of `bus_wdata` into that register's interrupt enable. The ready flag and the other bits of the register are not changed by the write.
- R9: A read of an I/O address other than the four registers returns 0, and a write to one has no effect. When `bus_valid` is 0, or the address is below 0xFE00, `bus_rdata` is 0.
- R10: After reset both interrupt enables are 0, keyboard-ready is 0, the held characters are 0 and `disp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | An access is in progress this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Access address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data from the selected register |
| mem_en | output | 1 | Enable for ordinary memory |
| kbd_valid | input | 1 | Keyboard source offers a character |
| kbd_ready | output | 1 | Bank can take a character |
| kbd_char | input | 8 | Keyboard character |
| disp_valid | output | 1 | A character is waiting for the display |
| disp_ready | input | 1 | Display sink accepts the character |
| disp_char | output | 8 | Character for the display |

## Verification
Two events can land in the same cycle: the processor reading the keyboard character word, and a new character arriving from the keyboard. The bench provokes this for every byte value. It holds a character, starts a read of 0xFE02 with the next byte already offered on the keyboard stream, and checks that `kbd_ready` is 1 while the read returns the old byte. After the edge it checks that the flag is still set and that 0xFE02 now returns the new byte. On the display side the bench writes 0xFE06 while a byte is still pending and checks that the pending byte survives unchanged until the sink accepts it.

// File: rtl/kdio_pkg.sv
package kdio_pkg;
  typedef enum logic [2:0] {
    SEL_NONE  = 3'd0,
    SEL_KSTAT = 3'd1,
    SEL_KCHAR = 3'd2,
    SEL_DSTAT = 3'd3,
    SEL_DCHAR = 3'd4,
    SEL_UNMAP = 3'd5
  } kdio_sel_e;
endpackage

// File: rtl/kdio_addr_decode.sv
module kdio_addr_decode
  import kdio_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] IO_BASE = 16'hFE00,
  parameter int KSTAT_OFF = 0,
  parameter int KCHAR_OFF = 2,
  parameter int DSTAT_OFF = 4,
  parameter int DCHAR_OFF = 6
) (
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  output logic              mem_en,
  output kdio_sel_e         sel
);
  localparam logic [ADDR_W-1:0] KSTAT_A = IO_BASE + ADDR_W'(KSTAT_OFF);
  localparam logic [ADDR_W-1:0] KCHAR_A = IO_BASE + ADDR_W'(KCHAR_OFF);
  localparam logic [ADDR_W-1:0] DSTAT_A = IO_BASE + ADDR_W'(DSTAT_OFF);
  localparam logic [ADDR_W-1:0] DCHAR_A = IO_BASE + ADDR_W'(DCHAR_OFF);

  logic in_io;
  assign in_io  = (addr >= IO_BASE);
  assign mem_en = valid & ~in_io;

  always_comb begin
    sel = SEL_NONE;
    if (valid && in_io) begin
      if      (addr == KSTAT_A) sel = SEL_KSTAT;
      else if (addr == KCHAR_A) sel = SEL_KCHAR;
      else if (addr == DSTAT_A) sel = SEL_DSTAT;
      else if (addr == DCHAR_A) sel = SEL_DCHAR;
      else                      sel = SEL_UNMAP;
    end
  end
endmodule

// File: rtl/kdio_kbd_port.sv
module kdio_kbd_port #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              ie_wr,
  input  logic              ie_val,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_char,
  output logic              in_ready,
  output logic              flag,
  output logic              ie,
  output logic [CHAR_W-1:0] held
);
  logic accept;
  assign in_ready = ~flag | take;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      held <= '0;
    end else if (accept) begin
      flag <= 1'b1;
      held <= in_char;
    end else if (take) begin
      flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ie <= 1'b0;
    else if (ie_wr) ie <= ie_val;
  end
endmodule

// File: rtl/kdio_disp_port.sv
module kdio_disp_port #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              put,
  input  logic [CHAR_W-1:0] put_char,
  input  logic              ie_wr,
  input  logic              ie_val,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CHAR_W-1:0] out_char,
  output logic              flag,
  output logic              ie
);
  logic load;
  assign out_valid = ~flag;
  assign load      = put & flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag     <= 1'b1;
      out_char <= '0;
    end else if (load) begin
      flag     <= 1'b0;
      out_char <= put_char;
    end else if (out_valid && out_ready) begin
      flag     <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ie <= 1'b0;
    else if (ie_wr) ie <= ie_val;
  end
endmodule

// File: rtl/kbd_disp_regbank.sv
module kbd_disp_regbank
  import kdio_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8,
  parameter logic [ADDR_W-1:0] IO_BASE = 16'hFE00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              mem_en,
  input  logic              kbd_valid,
  output logic              kbd_ready,
  input  logic [CHAR_W-1:0] kbd_char,
  output logic              disp_valid,
  input  logic              disp_ready,
  output logic [CHAR_W-1:0] disp_char
);
  localparam int RDY_BIT = DATA_W - 1;
  localparam int IE_BIT  = DATA_W - 2;

  kdio_sel_e sel;
  logic rd, wr;
  logic k_flag, k_ie, d_flag, d_ie;
  logic [CHAR_W-1:0] k_held;

  kdio_addr_decode #(.ADDR_W(ADDR_W), .IO_BASE(IO_BASE)) u_dec (
    .valid (bus_valid),
    .addr  (bus_addr),
    .mem_en(mem_en),
    .sel   (sel)
  );

  assign rd = bus_valid & ~bus_we;
  assign wr = bus_valid &  bus_we;

  kdio_kbd_port #(.CHAR_W(CHAR_W)) u_kbd (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (rd & (sel == SEL_KCHAR)),
    .ie_wr   (wr & (sel == SEL_KSTAT)),
    .ie_val  (bus_wdata[IE_BIT]),
    .in_valid(kbd_valid),
    .in_char (kbd_char),
    .in_ready(kbd_ready),
    .flag    (k_flag),
    .ie      (k_ie),
    .held    (k_held)
  );

  kdio_disp_port #(.CHAR_W(CHAR_W)) u_disp (
    .clk      (clk),
    .rst_n    (rst_n),
    .put      (wr & (sel == SEL_DCHAR)),
    .put_char (bus_wdata[CHAR_W-1:0]),
    .ie_wr    (wr & (sel == SEL_DSTAT)),
    .ie_val   (bus_wdata[IE_BIT]),
    .out_valid(disp_valid),
    .out_ready(disp_ready),
    .out_char (disp_char),
    .flag     (d_flag),
    .ie       (d_ie)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      unique case (sel)
        SEL_KSTAT: begin
          bus_rdata[RDY_BIT] = k_flag;
          bus_rdata[IE_BIT]  = k_ie;
        end
        SEL_DSTAT: begin
          bus_rdata[RDY_BIT] = d_flag;
          bus_rdata[IE_BIT]  = d_ie;
        end
        SEL_KCHAR: bus_rdata[CHAR_W-1:0] = k_held;
        SEL_DCHAR: bus_rdata[CHAR_W-1:0] = disp_char;
        default:   bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/kdio_checker.sv
module kdio_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8,
  parameter logic [ADDR_W-1:0] IO_BASE = 16'hFE00
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              mem_en,
  input logic              kbd_valid,
  input logic              kbd_ready,
  input logic              disp_valid,
  input logic              disp_ready,
  input logic [CHAR_W-1:0] disp_char
);
  localparam logic [ADDR_W-1:0] KCHAR_A = IO_BASE + ADDR_W'(2);
  localparam logic [ADDR_W-1:0] LAST_A  = IO_BASE + ADDR_W'(6);

  logic kread;
  assign kread = bus_valid && !bus_we && (bus_addr == KCHAR_A);

  assert_mem_off_io_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_addr >= IO_BASE) |-> !mem_en);

  assert_kbd_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (kbd_valid && kbd_ready) |=> (!kbd_ready || kread));

  assert_kbd_drain_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (kread && !kbd_valid) |=> kbd_ready);

  assert_disp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !disp_ready) |=> (disp_valid && $stable(disp_char)));

  assert_disp_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ready) |=> !disp_valid);

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_valid || bus_we || bus_addr < IO_BASE || bus_addr > LAST_A) |-> (bus_rdata == '0));
endmodule

bind kbd_disp_regbank kdio_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAR_W(CHAR_W), .IO_BASE(IO_BASE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .mem_en    (mem_en),
  .kbd_valid (kbd_valid),
  .kbd_ready (kbd_ready),
  .disp_valid(disp_valid),
  .disp_ready(disp_ready),
  .disp_char (disp_char)
);

// File: tb/kbd_disp_regbank_tb.sv
module kbd_disp_regbank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_we = 1'b0;
  logic [15:0] bus_addr = '0, bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        mem_en;
  logic        kbd_valid = 1'b0;
  logic        kbd_ready;
  logic [7:0]  kbd_char = '0;
  logic        disp_valid;
  logic        disp_ready = 1'b0;
  logic [7:0]  disp_char;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  kbd_disp_regbank u_dut (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mem_en(mem_en),
    .kbd_valid(kbd_valid), .kbd_ready(kbd_ready), .kbd_char(kbd_char),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_char(disp_char)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle;
    bus_valid = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
  endtask

  // read with combinational check, side effect applied by the following edge
  task automatic rd(input string req, input logic [15:0] a, input logic [15:0] exp);
    bus_valid = 1; bus_we = 0; bus_addr = a;
    #1 chk(req, bus_rdata, exp);
    step();
    idle();
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    bus_valid = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    step();
    idle();
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic kie, die;
    kie = 0; die = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    #1;
    chk("R10 disp_valid", {31'd0, disp_valid}, 32'd0);
    chk("R10 kbd_ready", {31'd0, kbd_ready}, 32'd1);
    rd("R10/R2 kstat", 16'hFE00, 16'h0000);
    rd("R10/R5 dstat", 16'hFE04, 16'h8000);
    rd("R10 kchar", 16'hFE02, 16'h0000);

    // R1/R9 sweep of every address, read
    for (int a = 0; a < 65536; a++) begin
      logic [15:0] e;
      bus_valid = 1; bus_we = 0; bus_addr = 16'(a);
      e = (a == 16'hFE04) ? 16'h8000 : 16'h0000;
      #1;
      chk("R1 mem_en", {31'd0, mem_en}, {31'd0, (a < 16'hFE00)});
      chk("R9 rdata", {16'd0, bus_rdata}, {16'd0, e});
      step();
    end
    idle();
    #1 chk("R1 idle mem_en", {31'd0, mem_en}, 32'd0);
    chk("R9 idle rdata", {16'd0, bus_rdata}, 32'd0);

    // R9 unmapped writes no effect
    wr(16'hFE01, 16'hFFFF); wr(16'hFE08, 16'hFFFF); wr(16'hFFFE, 16'hFFFF);
    rd("R9 kstat after unmapped wr", 16'hFE00, 16'h0000);
    rd("R9 dstat after unmapped wr", 16'hFE04, 16'h8000);
    #1 chk("R9 disp_valid", {31'd0, disp_valid}, 32'd0);

    // R8 interrupt enable bits
    wr(16'hFE00, 16'hFFFF); kie = 1;
    rd("R8 kstat ie set", 16'hFE00, 16'h4000);
    wr(16'hFE04, 16'h7FFF); die = 1;
    rd("R8 dstat ie set", 16'hFE04, 16'hC000);
    wr(16'hFE04, 16'hBFFF); die = 0;
    rd("R8 dstat ie clr", 16'hFE04, 16'h8000);

    // R3/R4 keyboard sweep
    for (int b = 0; b < 256; b++) begin
      kbd_valid = 1; kbd_char = 8'(b);
      #1 chk("R3 kbd_ready empty", {31'd0, kbd_ready}, 32'd1);
      step();
      kbd_valid = 0;
      #1 chk("R3 kbd_ready full", {31'd0, kbd_ready}, 32'd0);
      rd("R2 kstat full", 16'hFE00, {1'b1, kie, 14'd0});
      rd("R4 kchar", 16'hFE02, {8'd0, 8'(b)});
      rd("R4 kstat cleared", 16'hFE00, {1'b0, kie, 14'd0});
    end

    // R4 read and arrival in the same cycle
    kbd_valid = 1; kbd_char = 8'h00; step(); kbd_valid = 0;
    for (int b = 1; b < 256; b++) begin
      bus_valid = 1; bus_we = 0; bus_addr = 16'hFE02;
      kbd_valid = 1; kbd_char = 8'(b);
      #1;
      chk("R3 ready during read", {31'd0, kbd_ready}, 32'd1);
      chk("R4 old char", {16'd0, bus_rdata}, {24'd0, 8'(b - 1)});
      step();
      kbd_valid = 0; idle();
      rd("R4 flag kept", 16'hFE00, {1'b1, kie, 14'd0});
    end
    rd("R4 last char", 16'hFE02, 16'h00FF);
    rd("R4 final clear", 16'hFE00, {1'b0, kie, 14'd0});

    // R6/R7 display sweep
    for (int b = 0; b < 256; b++) begin
      wr(16'hFE06, {8'hA5, 8'(b)});
      #1;
      chk("R6 disp_valid", {31'd0, disp_valid}, 32'd1);
      chk("R6 disp_char", {24'd0, disp_char}, {24'd0, 8'(b)});
      rd("R6 dstat busy", 16'hFE04, {1'b0, die, 14'd0});
      wr(16'hFE06, {8'h00, ~8'(b)});
      #1 chk("R6 ignored write", {24'd0, disp_char}, {24'd0, 8'(b)});
      rd("R7 dchar hold", 16'hFE06, {8'd0, 8'(b)});
      chk("R7 still valid", {31'd0, disp_valid}, 32'd1);
      disp_ready = 1;
      step();
      disp_ready = 0;
      #1 chk("R7 drop", {31'd0, disp_valid}, 32'd0);
      rd("R7 dstat ready", 16'hFE04, {1'b1, die, 14'd0});
      if (b == 128) begin
        wr(16'hFE04, 16'h4000); die = 1;
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule